// File: doc/BRIEF.md
# RGB Macroblock Luma/Chroma Splitter

This block takes a stream of 16x16 RGB pixel regions, one pixel per input beat in raster order (left to right, then top to bottom). It turns each pixel into one luminance sample and two colour-difference samples using fixed-point coefficients. It then writes two output streams. The luminance stream carries four 8x8 blocks per region at full resolution. The chrominance stream carries one 8x8 blue-difference block and one 8x8 red-difference block, each decimated 4:1 by averaging 2x2 neighbourhoods.

A whole region is captured before any output starts. The input then stays stalled while both output streams drain, and each output stream runs independently under its own backpressure. A marker beat on the input signals the end of the stream. That marker is passed on as a single marker beat on each output stream.

The controller has three states. ST_FILL accepts input. ST_DRAIN emits the six blocks. ST_MARK emits the end-of-stream marker. There are four transitions:
- ST_FILL goes to ST_DRAIN when the 256th pixel is accepted.
- ST_FILL goes to ST_MARK when a marker beat is accepted.
- ST_DRAIN goes to ST_FILL once both streams have emitted their last sample.
- ST_MARK goes to ST_FILL once both markers have been taken.

Top module: `mb_splitter`

## Requirements
- R1: Each luminance sample equals ((66R + 129G + 25B + 128) >> 8) + 16, computed on the unsigned 8-bit inputs.
- R2: Full-resolution colour-difference values are Cb = ((-38R - 74G + 112B + 128) >>> 8) + 128 and Cr = ((112R - 94G - 18B + 128) >>> 8) + 128. The shift is arithmetic, and each value is clamped to 0..255.
- R3: Each chroma output sample is (s + 2) >> 2. Here s is the sum of the four full-resolution values in one aligned 2x2 pixel group.
- R4: Luminance output index k = 64*b + 8*row + col, with b = 0..3 meaning top-left, top-right, bottom-left, bottom-right. It carries pixel (x = 8*(b&1) + col, y = 8*(b>>1) + row) of the region.
- R5: Chrominance output indices 0..63 are the Cb block and 64..127 the Cr block. Each block is in row-major order, and index 8*r + c covers pixels x = 2c..2c+1, y = 2r..2r+1.
- R6: From the cycle after the 256th pixel is accepted until both streams are drained, in_ready is low. in_ready is high again the cycle after the final output handshake.
- R7: While an output's valid is high and its ready is low, that valid stays high and its data and marker flag stay unchanged on the next cycle.
- R8: An input beat with in_eos high carries no pixel. It produces exactly one beat on each output with the marker flag set and data 0, after which input is accepted again.
- R9: After reset, in_ready is high and both output valids are low.
- R10: Each region yields exactly 256 luminance beats and 128 chrominance beats, with no extra beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_eos | input | 1 | Beat is an end-of-stream marker, not a pixel |
| in_r | input | 8 | Red byte |
| in_g | input | 8 | Green byte |
| in_b | input | 8 | Blue byte |
| y_valid | output | 1 | Luminance beat valid |
| y_ready | input | 1 | Luminance sink ready |
| y_data | output | 8 | Luminance sample |
| y_eos | output | 1 | Luminance beat is the end marker |
| c_valid | output | 1 | Chrominance beat valid |
| c_ready | input | 1 | Chrominance sink ready |
| c_data | output | 8 | Chrominance sample |
| c_eos | output | 1 | Chrominance beat is the end marker |

## Verification
The first luminance and chrominance beats of a region become valid one cycle after the clock edge that accepts the 256th pixel. The end marker likewise appears one cycle after the marker input is accepted. in_ready returns one cycle after the slower stream's last handshake. Output valids never depend on ready, so the bench sets each ready on the falling edge and records a beat there whenever valid and ready are both high; that beat is the one transferred at the following rising edge. A beat held under backpressure is compared against the value recorded one falling edge earlier.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int SAMPLE_W = 8;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_DRAIN,
        ST_MARK
    } mbs_state_e;

    // Saturate a signed intermediate to an unsigned byte.
    function automatic logic [SAMPLE_W-1:0] clamp_u8(input logic signed [18:0] v);
        if (v < 0)
            return '0;
        else if (v > 19'sd255)
            return 8'd255;
        else
            return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/mbs_convert.sv
module mbs_convert
    import mbs_pkg::*;
(
    input  logic [SAMPLE_W-1:0] r,
    input  logic [SAMPLE_W-1:0] g,
    input  logic [SAMPLE_W-1:0] b,
    output logic [SAMPLE_W-1:0] luma,
    output logic [SAMPLE_W-1:0] cb,
    output logic [SAMPLE_W-1:0] cr
);

    logic signed [18:0] r_s, g_s, b_s;
    logic signed [18:0] y_acc, cb_acc, cr_acc;

    assign r_s = {11'd0, r};
    assign g_s = {11'd0, g};
    assign b_s = {11'd0, b};

    always_comb begin
        y_acc  = 19'sd66 * r_s + 19'sd129 * g_s + 19'sd25 * b_s + 19'sd128;
        cb_acc = 19'sd112 * b_s - 19'sd38 * r_s - 19'sd74 * g_s + 19'sd128;
        cr_acc = 19'sd112 * r_s - 19'sd94 * g_s - 19'sd18 * b_s + 19'sd128;
        luma   = clamp_u8((y_acc  >>> 8) + 19'sd16);
        cb     = clamp_u8((cb_acc >>> 8) + 19'sd128);
        cr     = clamp_u8((cr_acc >>> 8) + 19'sd128);
    end

endmodule

// File: rtl/mbs_buffer.sv
module mbs_buffer
    import mbs_pkg::*;
#(
    parameter int MB_DIM = 16
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(MB_DIM*MB_DIM)-1:0] wr_idx,
    input  logic [SAMPLE_W-1:0]           wr_y,
    input  logic [SAMPLE_W-1:0]           wr_cb,
    input  logic [SAMPLE_W-1:0]           wr_cr,
    input  logic [$clog2(MB_DIM*MB_DIM)-1:0] rd_y_idx,
    output logic [SAMPLE_W-1:0]           rd_y,
    input  logic [$clog2(MB_DIM*MB_DIM)-2:0] rd_c_idx,
    output logic [SAMPLE_W-1:0]           rd_c
);

    localparam int MB_PIX = MB_DIM * MB_DIM;
    localparam int PIX_W  = $clog2(MB_PIX);
    localparam int XW     = $clog2(MB_DIM);
    localparam int BW     = XW - 1;
    localparam int C_PIX  = MB_PIX / 4;
    localparam int CPIX_W = PIX_W - 2;
    localparam int SUM_W  = SAMPLE_W + 2;

    logic [SAMPLE_W-1:0] luma_mem [MB_PIX];
    logic [SUM_W-1:0]    cb_sum   [C_PIX];
    logic [SUM_W-1:0]    cr_sum   [C_PIX];

    // Write side: raster position split into column and row.
    logic [XW-1:0]     wx, wy;
    logic [CPIX_W-1:0] wgrp;
    logic              grp_first;

    assign wx        = wr_idx[XW-1:0];
    assign wy        = wr_idx[PIX_W-1:XW];
    assign wgrp      = {wy[XW-1:1], wx[XW-1:1]};
    assign grp_first = !wx[0] && !wy[0];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            luma_mem[wr_idx] <= wr_y;
            if (grp_first) begin
                cb_sum[wgrp] <= {2'b00, wr_cb};
                cr_sum[wgrp] <= {2'b00, wr_cr};
            end else begin
                cb_sum[wgrp] <= cb_sum[wgrp] + {2'b00, wr_cb};
                cr_sum[wgrp] <= cr_sum[wgrp] + {2'b00, wr_cr};
            end
        end
    end

    // Luma read: output index {block, row, col} mapped to raster {y, x}.
    logic [1:0]      ry_blk;
    logic [BW-1:0]   ry_row, ry_col;
    logic [PIX_W-1:0] ry_addr;

    assign ry_blk  = rd_y_idx[PIX_W-1:PIX_W-2];
    assign ry_row  = rd_y_idx[PIX_W-3:BW];
    assign ry_col  = rd_y_idx[BW-1:0];
    assign ry_addr = {ry_blk[1], ry_row, ry_blk[0], ry_col};
    assign rd_y    = luma_mem[ry_addr];

    // Chroma read: top index bit picks the channel, then a rounded mean.
    logic [SUM_W-1:0] sel_sum;
    logic [SUM_W:0]   rounded;

    assign sel_sum = rd_c_idx[CPIX_W] ? cr_sum[rd_c_idx[CPIX_W-1:0]]
                                      : cb_sum[rd_c_idx[CPIX_W-1:0]];
    assign rounded = {1'b0, sel_sum} + (SUM_W+1)'(2);
    assign rd_c    = rounded[SUM_W-1:2];

endmodule

// File: rtl/mb_splitter.sv
module mb_splitter
    import mbs_pkg::*;
#(
    parameter int MB_DIM = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_eos,
    input  logic [SAMPLE_W-1:0] in_r,
    input  logic [SAMPLE_W-1:0] in_g,
    input  logic [SAMPLE_W-1:0] in_b,
    output logic                y_valid,
    input  logic                y_ready,
    output logic [SAMPLE_W-1:0] y_data,
    output logic                y_eos,
    output logic                c_valid,
    input  logic                c_ready,
    output logic [SAMPLE_W-1:0] c_data,
    output logic                c_eos
);

    localparam int MB_PIX = MB_DIM * MB_DIM;
    localparam int PIX_W  = $clog2(MB_PIX);
    localparam int C_CNT  = MB_PIX / 2;
    localparam int CW     = $clog2(C_CNT);

    mbs_state_e       state, state_nx;
    logic [PIX_W-1:0] pix_cnt, y_cnt;
    logic [CW-1:0]    c_cnt;
    logic             y_done, c_done;

    logic [SAMPLE_W-1:0] cv_y, cv_cb, cv_cr, rd_y, rd_c;
    logic px_fire, eos_fire, y_fire, c_fire;
    logic y_last, c_last, y_fin, c_fin;

    mbs_convert u_conv (
        .r    (in_r),
        .g    (in_g),
        .b    (in_b),
        .luma (cv_y),
        .cb   (cv_cb),
        .cr   (cv_cr)
    );

    mbs_buffer #(.MB_DIM(MB_DIM)) u_buf (
        .clk      (clk),
        .wr_en    (px_fire),
        .wr_idx   (pix_cnt),
        .wr_y     (cv_y),
        .wr_cb    (cv_cb),
        .wr_cr    (cv_cr),
        .rd_y_idx (y_cnt),
        .rd_y     (rd_y),
        .rd_c_idx (c_cnt),
        .rd_c     (rd_c)
    );

    assign px_fire  = in_valid && in_ready && !in_eos;
    assign eos_fire = in_valid && in_ready && in_eos;
    assign y_fire   = y_valid && y_ready;
    assign c_fire   = c_valid && c_ready;
    assign y_last   = (state == ST_MARK) || (y_cnt == PIX_W'(MB_PIX - 1));
    assign c_last   = (state == ST_MARK) || (c_cnt == CW'(C_CNT - 1));
    assign y_fin    = y_done || (y_fire && y_last);
    assign c_fin    = c_done || (c_fire && c_last);

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: begin
                if (eos_fire)
                    state_nx = ST_MARK;
                else if (px_fire && pix_cnt == PIX_W'(MB_PIX - 1))
                    state_nx = ST_DRAIN;
            end
            ST_DRAIN, ST_MARK: begin
                if (y_fin && c_fin)
                    state_nx = ST_FILL;
            end
            default: state_nx = ST_FILL;
        endcase
    end

    // State register and sequencing counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FILL;
            pix_cnt <= '0;
            y_cnt   <= '0;
            c_cnt   <= '0;
            y_done  <= 1'b0;
            c_done  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) begin
                y_cnt  <= '0;
                c_cnt  <= '0;
                y_done <= 1'b0;
                c_done <= 1'b0;
                if (eos_fire)
                    pix_cnt <= '0;
                else if (px_fire)
                    pix_cnt <= pix_cnt + 1'b1;
            end else begin
                if (y_fire) begin
                    y_cnt <= y_cnt + 1'b1;
                    if (y_last)
                        y_done <= 1'b1;
                end
                if (c_fire) begin
                    c_cnt <= c_cnt + 1'b1;
                    if (c_last)
                        c_done <= 1'b1;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        in_ready = (state == ST_FILL);
        y_valid  = (state != ST_FILL) && !y_done;
        c_valid  = (state != ST_FILL) && !c_done;
        y_eos    = (state == ST_MARK);
        c_eos    = (state == ST_MARK);
        y_data   = (state == ST_MARK) ? '0 : rd_y;
        c_data   = (state == ST_MARK) ? '0 : rd_c;
    end

    // R7: luminance output held under backpressure.
    p_y_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid && !y_ready |=> y_valid && $stable(y_data) && $stable(y_eos));

    // R7: chrominance output held under backpressure.
    p_c_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid && !c_ready |=> c_valid && $stable(c_data) && $stable(c_eos));

    // R6: no input accepted while any output is pending.
    p_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid || c_valid) |-> !in_ready);

    // R1: luminance samples stay in the nominal range.
    p_luma_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid && !y_eos |-> (y_data >= 8'd16 && y_data <= 8'd235));

    // R2: averaged chroma samples stay in the nominal range.
    p_chroma_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid && !c_eos |-> (c_data >= 8'd16 && c_data <= 8'd240));

    // R6: the last pixel of a region closes the input on the next cycle.
    p_close_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_eos && pix_cnt == PIX_W'(MB_PIX - 1)
        |=> !in_ready && y_valid && c_valid);

endmodule

// File: tb/tb_mb_splitter.sv
module tb_mb_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NPIX       = 256;
    localparam int NCHR       = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_eos = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic in_ready;
    logic y_valid, y_eos, c_valid, c_eos;
    logic y_ready = 1'b0, c_ready = 1'b0;
    logic [7:0] y_data, c_data;

    mb_splitter dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_eos(in_eos),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .y_eos(y_eos),
        .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data), .c_eos(c_eos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) timed_out <= 1'b1;
    end

    byte unsigned pr [NPIX], pg [NPIX], pb [NPIX];
    int exp_y [NPIX];
    int exp_c [NCHR];
    int yi = 0, ci = 0;
    bit mode_eos = 1'b0, got_y_eos = 1'b0, got_c_eos = 1'b0;
    bit bp_on = 1'b0;
    bit y_pend = 1'b0, c_pend = 1'b0;
    logic [7:0] y_prev, c_prev;

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction
    function automatic int f_luma(input int r, input int g, input int b);
        return clamp(((66*r + 129*g + 25*b + 128) >>> 8) + 16);
    endfunction
    function automatic int f_cb(input int r, input int g, input int b);
        return clamp(((-38*r - 74*g + 112*b + 128) >>> 8) + 128);
    endfunction
    function automatic int f_cr(input int r, input int g, input int b);
        return clamp(((112*r - 94*g - 18*b + 128) >>> 8) + 128);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic build_expect();
        int sb [64];
        int sr [64];
        for (int i = 0; i < 64; i++) begin sb[i] = 0; sr[i] = 0; end
        for (int p = 0; p < NPIX; p++) begin
            int x = p % 16;
            int yy = p / 16;
            int blk = (yy / 8) * 2 + (x / 8);
            exp_y[blk*64 + (yy % 8)*8 + (x % 8)] = f_luma(pr[p], pg[p], pb[p]);
            sb[(yy/2)*8 + x/2] += f_cb(pr[p], pg[p], pb[p]);
            sr[(yy/2)*8 + x/2] += f_cr(pr[p], pg[p], pb[p]);
        end
        for (int i = 0; i < 64; i++) begin
            exp_c[i]      = (sb[i] + 2) >> 2;
            exp_c[64 + i] = (sr[i] + 2) >> 2;
        end
    endtask

    // Luminance sink: ready chosen first, then the beat sampled.
    always @(negedge clk) begin
        if (rst_n) begin
            if (y_pend)
                check(y_valid && y_data == y_prev, "R7 luma hold", y_data, y_prev);
            y_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
            y_pend = y_valid && !y_ready;
            y_prev = y_data;
            if (y_valid && y_ready) begin
                if (y_eos) begin
                    check(mode_eos && y_data == 0 && !got_y_eos, "R8 luma marker", y_data, 0);
                    got_y_eos = 1'b1;
                end else if (mode_eos || yi >= NPIX) begin
                    check(1'b0, "R10 extra luma beat", yi, NPIX);
                end else begin
                    check(y_data == exp_y[yi], $sformatf("R1 R4 luma idx %0d", yi), y_data, exp_y[yi]);
                    yi++;
                end
            end
        end
    end

    // Chrominance sink.
    always @(negedge clk) begin
        if (rst_n) begin
            if (c_pend)
                check(c_valid && c_data == c_prev, "R7 chroma hold", c_data, c_prev);
            c_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
            c_pend = c_valid && !c_ready;
            c_prev = c_data;
            if (c_valid && c_ready) begin
                if (c_eos) begin
                    check(mode_eos && c_data == 0 && !got_c_eos, "R8 chroma marker", c_data, 0);
                    got_c_eos = 1'b1;
                end else if (mode_eos || ci >= NCHR) begin
                    check(1'b0, "R10 extra chroma beat", ci, NCHR);
                end else begin
                    check(c_data == exp_c[ci], $sformatf("R2 R3 R5 chroma idx %0d", ci), c_data, exp_c[ci]);
                    ci++;
                end
            end
        end
    end

    // R6: input stays closed while outputs are pending.
    always @(negedge clk) begin
        if (rst_n && (y_valid || c_valid) && in_ready)
            check(1'b0, "R6 input open during drain", 1, 0);
    end

    task automatic drive_beat(input bit eos, input int p);
        @(negedge clk);
        while (bp_on && ($urandom % 5 == 0) && !timed_out) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_eos = eos;
        in_r = eos ? 8'd0 : pr[p];
        in_g = eos ? 8'd0 : pg[p];
        in_b = eos ? 8'd0 : pb[p];
        while (!in_ready && !timed_out) @(negedge clk);
    endtask

    task automatic run_region();
        build_expect();
        yi = 0; ci = 0;
        for (int p = 0; p < NPIX; p++) drive_beat(1'b0, p);
        @(negedge clk);
        in_valid = 1'b0;
        while (!(yi == NPIX && ci == NCHR) && !timed_out) @(negedge clk);
        repeat (3) @(negedge clk);
        check(yi == NPIX, "R10 luma count", yi, NPIX);
        check(ci == NCHR, "R10 chroma count", ci, NCHR);
        check(in_ready && !y_valid && !c_valid, "R6 input reopened", in_ready, 1);
    endtask

    task automatic run_marker();
        mode_eos = 1'b1; got_y_eos = 1'b0; got_c_eos = 1'b0;
        drive_beat(1'b1, 0);
        @(negedge clk);
        in_valid = 1'b0;
        in_eos = 1'b0;
        while (!(got_y_eos && got_c_eos) && !timed_out) @(negedge clk);
        repeat (2) @(negedge clk);
        check(got_y_eos && got_c_eos, "R8 both markers", got_y_eos + got_c_eos, 2);
        check(in_ready && !y_valid && !c_valid, "R8 input reopened after marker", in_ready, 1);
        mode_eos = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        check(!y_valid && !c_valid, "R9 reset valids", y_valid + c_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !y_valid && !c_valid, "R9 after reset", in_ready, 1);

        // Directed: black, white, gradient, 2x2 rounding pattern.
        for (int p = 0; p < NPIX; p++) begin pr[p] = 0; pg[p] = 0; pb[p] = 0; end
        run_region();
        for (int p = 0; p < NPIX; p++) begin pr[p] = 255; pg[p] = 255; pb[p] = 255; end
        run_region();
        for (int p = 0; p < NPIX; p++) begin
            pr[p] = byte'((p % 16) * 16);
            pg[p] = byte'((p / 16) * 16);
            pb[p] = byte'(255 - p);
        end
        run_region();
        for (int p = 0; p < NPIX; p++) begin
            pr[p] = ((p % 2) == 0) ? 8'd255 : 8'd0;
            pg[p] = 8'd0;
            pb[p] = ((p / 16) % 2 == 0) ? 8'd0 : 8'd255;
        end
        run_region();

        // Random regions with random stalls on every side.
        for (int m = 0; m < 6; m++) begin
            bp_on = (m % 3 != 0);
            for (int p = 0; p < NPIX; p++) begin
                pr[p] = byte'($urandom);
                pg[p] = byte'($urandom);
                pb[p] = byte'($urandom);
            end
            run_region();
        end

        bp_on = 1'b1;
        run_marker();
        for (int p = 0; p < NPIX; p++) begin
            pr[p] = byte'($urandom); pg[p] = byte'($urandom); pb[p] = byte'($urandom);
        end
        run_region();

        if (timed_out) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule